// File: doc/BRIEF.md
# I2C Master Status, Interrupt and Transmit-Lock Controller

This block keeps the status word of an I2C master controller. It tracks whether the transmit holding register and the receive holding register are occupied. It holds the sticky error flags and the enable mask for the interrupt line. It also drives the request line that asks a DMA engine for the next transmit byte. The bus engine feeds it single-cycle event pulses: a byte was received, the shifter wants the next transmit byte, the slave answered with a NACK, and the STOP condition went out. It also receives a level that is high while the shifter is idle. The host side supplies single-cycle pulses for holding-register writes and reads, status reads, mask writes and control actions.

Transmission-complete is a live level and not a stored flag. It is high only while the transmit holding register is empty, the shifter is idle and a STOP or NACK has ended the transfer. A NACK sets a transmit lock. While the lock is set, DMA transmit requests are withheld and any byte in the transmit holding register stays put. A control pulse releases the lock. Software can then flush the stale byte with a separate control pulse.

Top module: `i2c_status_lock`

## Requirements
- R1: Out of reset, with the shifter idle, the status word reads 0x00000005 (bit 0 transmission complete, bit 2 transmit ready). The interrupt mask is zero, `irq` is low and `dma_tx_req` is high.
- R2: Status bit 0 (transmission complete) equals: transmit holding register empty AND `shifter_idle` AND a transfer-ended flag. That flag is set by `ev_stop` or `ev_nack`, is cleared by `thr_wr` or `start_rd`, and a clear wins over a set in the same cycle. The flag is set at reset.
- R3: One cycle after `ev_nack`, status bit 8 (NACK) and bit 23 (lock) are high. Bit 0 is also high if the holding register is empty and the shifter is idle.
- R4: While bit 23 is high, `dma_tx_req` is low. A `tx_load` pulse neither empties the transmit holding register nor raises underrun, so a byte written after the NACK keeps bit 0 and bit 2 low.
- R5: `thr_clr` empties the transmit holding register and wins over a `thr_wr` in the same cycle. `rhr_clr` clears receive ready. `lock_clr` clears bit 23, except that an `ev_nack` in the same cycle keeps it set.
- R6: Status bit 1 (receive ready) is set one cycle after `rx_byte`. It is cleared after `rhr_rd` or `rhr_clr`, and an `rx_byte` in the same cycle wins.
- R7: Status bit 6 (overrun) sets when `rx_byte` arrives while bit 1 is high and neither `rhr_rd` nor `rhr_clr` is pulsed in that cycle.
- R8: Status bit 7 (underrun) sets when `tx_load` arrives while the transmit holding register is empty and the lock is clear. Otherwise `tx_load` empties a full register (bit 2 high next cycle).
- R9: Bits 6, 7 and 8 are sticky and clear one cycle after `sr_rd`, unless their setting event arrives in that same cycle.
- R10: `ier_wr` sets and `idr_wr` clears mask bits from `mask_wdata`, only at positions 0, 1, 2, 6, 7, 8 and 23. A disable wins over an enable of the same bit in the same cycle.
- R11: `irq` is the OR over all bits of (status AND mask), with no added delay.
- R12: `dma_tx_req` is high exactly when the transmit holding register is empty (status bit 2) and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_wr | input | 1 | Host or DMA write of the transmit holding register |
| thr_clr | input | 1 | Control pulse: flush the transmit holding register |
| rhr_rd | input | 1 | Host or DMA read of the receive holding register |
| rhr_clr | input | 1 | Control pulse: flush the receive holding register |
| lock_clr | input | 1 | Control pulse: release the transmit lock |
| start_rd | input | 1 | START written for a read transfer |
| sr_rd | input | 1 | Status word read (clears sticky flags) |
| ier_wr | input | 1 | Interrupt enable write (write one to set) |
| idr_wr | input | 1 | Interrupt disable write (write one to clear) |
| mask_wdata | input | 32 | Data for the enable and disable writes |
| tx_load | input | 1 | Shifter requests the next transmit byte |
| rx_byte | input | 1 | Bus engine finished receiving a byte |
| ev_nack | input | 1 | Slave did not acknowledge |
| ev_stop | input | 1 | STOP condition has been sent |
| shifter_idle | input | 1 | Level: the shifter holds no byte |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt line |
| dma_tx_req | output | 1 | Transmit request to the DMA engine |

## Verification
The collisions that matter are a clear and a set that land on the same state bit in one cycle. Examples are a status read beside a fresh NACK, a lock release beside a NACK, a receive-register read beside a new byte, and an enable beside a disable of the same mask bit. Directed steps pulse both inputs in one cycle and require the surviving value named in R5, R6, R9 and R10. A long random phase pulses all inputs independently, so these pairs also meet at random points inside transfers. Every field of the status word, `irq` and `dma_tx_req` is compared each cycle against a bench model built from the requirements.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;
    localparam int STAT_W   = 32;
    localparam int B_TXCOMP = 0;
    localparam int B_RXRDY  = 1;
    localparam int B_TXRDY  = 2;
    localparam int B_OVR    = 6;
    localparam int B_UNR    = 7;
    localparam int B_NACK   = 8;
    localparam int B_LOCK   = 23;

    function automatic logic [STAT_W-1:0] valid_bits();
        logic [STAT_W-1:0] v;
        v = '0;
        v[B_TXCOMP] = 1'b1;
        v[B_RXRDY]  = 1'b1;
        v[B_TXRDY]  = 1'b1;
        v[B_OVR]    = 1'b1;
        v[B_UNR]    = 1'b1;
        v[B_NACK]   = 1'b1;
        v[B_LOCK]   = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/i2c_sl_hold.sv
module i2c_sl_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic thr_clr,
    input  logic rhr_rd,
    input  logic rhr_clr,
    input  logic lock_clr,
    input  logic start_rd,
    input  logic tx_load,
    input  logic rx_byte,
    input  logic ev_nack,
    input  logic ev_stop,
    input  logic shifter_idle,
    output logic thr_full,
    output logic rx_rdy,
    output logic locked,
    output logic tx_done,
    output logic unr_ev,
    output logic ovr_ev
);
    typedef struct packed {
        logic thr_full;
        logic rx_rdy;
        logic lock;
        logic ended;
    } hold_t;

    hold_t st_d, st_q;
    logic  load_ok_d;
    logic  rx_take_d;

    always_comb begin
        st_d      = st_q;
        load_ok_d = tx_load && !st_q.lock;
        rx_take_d = rhr_rd || rhr_clr;

        if (thr_clr)
            st_d.thr_full = 1'b0;
        else if (thr_wr)
            st_d.thr_full = 1'b1;
        else if (load_ok_d)
            st_d.thr_full = 1'b0;

        if (rx_byte)
            st_d.rx_rdy = 1'b1;
        else if (rx_take_d)
            st_d.rx_rdy = 1'b0;

        if (ev_nack)
            st_d.lock = 1'b1;
        else if (lock_clr)
            st_d.lock = 1'b0;

        if (thr_wr || start_rd)
            st_d.ended = 1'b0;
        else if (ev_stop || ev_nack)
            st_d.ended = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{thr_full: 1'b0, rx_rdy: 1'b0, lock: 1'b0, ended: 1'b1};
        else
            st_q <= st_d;
    end

    assign thr_full = st_q.thr_full;
    assign rx_rdy   = st_q.rx_rdy;
    assign locked   = st_q.lock;
    assign tx_done  = !st_q.thr_full && shifter_idle && st_q.ended;
    assign unr_ev   = load_ok_d && !st_q.thr_full;
    assign ovr_ev   = rx_byte && st_q.rx_rdy && !rx_take_d;
endmodule

// File: rtl/i2c_sl_flags.sv
module i2c_sl_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_rd,
    input  logic nack_ev,
    input  logic ovr_ev,
    input  logic unr_ev,
    output logic nack,
    output logic ovr,
    output logic unr
);
    typedef struct packed {
        logic nack;
        logic ovr;
        logic unr;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d.nack = nack_ev || (st_q.nack && !sr_rd);
        st_d.ovr  = ovr_ev  || (st_q.ovr  && !sr_rd);
        st_d.unr  = unr_ev  || (st_q.unr  && !sr_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign nack = st_q.nack;
    assign ovr  = st_q.ovr;
    assign unr  = st_q.unr;
endmodule

// File: rtl/i2c_sl_irq.sv
module i2c_sl_irq
    import i2c_sl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic              idr_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic [STAT_W-1:0] status,
    output logic              irq
);
    localparam logic [STAT_W-1:0] VALID = valid_bits();

    typedef struct packed {
        logic [STAT_W-1:0] mask;
    } irq_t;

    irq_t              st_d, st_q;
    logic [STAT_W-1:0] set_d, clr_d;

    always_comb begin
        set_d       = ier_wr ? (mask_wdata & VALID) : '0;
        clr_d       = idr_wr ? mask_wdata : '0;
        st_d.mask   = (st_q.mask | set_d) & ~clr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq = |(status & st_q.mask);
endmodule

// File: rtl/i2c_status_lock.sv
module i2c_status_lock
    import i2c_sl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr,
    input  logic              thr_clr,
    input  logic              rhr_rd,
    input  logic              rhr_clr,
    input  logic              lock_clr,
    input  logic              start_rd,
    input  logic              sr_rd,
    input  logic              ier_wr,
    input  logic              idr_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              tx_load,
    input  logic              rx_byte,
    input  logic              ev_nack,
    input  logic              ev_stop,
    input  logic              shifter_idle,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              dma_tx_req
);
    logic thr_full, rx_rdy, locked, tx_done, unr_ev, ovr_ev;
    logic nack_f, ovr_f, unr_f;

    i2c_sl_hold u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_wr       (thr_wr),
        .thr_clr      (thr_clr),
        .rhr_rd       (rhr_rd),
        .rhr_clr      (rhr_clr),
        .lock_clr     (lock_clr),
        .start_rd     (start_rd),
        .tx_load      (tx_load),
        .rx_byte      (rx_byte),
        .ev_nack      (ev_nack),
        .ev_stop      (ev_stop),
        .shifter_idle (shifter_idle),
        .thr_full     (thr_full),
        .rx_rdy       (rx_rdy),
        .locked       (locked),
        .tx_done      (tx_done),
        .unr_ev       (unr_ev),
        .ovr_ev       (ovr_ev)
    );

    i2c_sl_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .sr_rd   (sr_rd),
        .nack_ev (ev_nack),
        .ovr_ev  (ovr_ev),
        .unr_ev  (unr_ev),
        .nack    (nack_f),
        .ovr     (ovr_f),
        .unr     (unr_f)
    );

    always_comb begin
        status           = '0;
        status[B_TXCOMP] = tx_done;
        status[B_RXRDY]  = rx_rdy;
        status[B_TXRDY]  = !thr_full;
        status[B_OVR]    = ovr_f;
        status[B_UNR]    = unr_f;
        status[B_NACK]   = nack_f;
        status[B_LOCK]   = locked;
    end

    i2c_sl_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ier_wr     (ier_wr),
        .idr_wr     (idr_wr),
        .mask_wdata (mask_wdata),
        .status     (status),
        .irq        (irq)
    );

    assign dma_tx_req = !thr_full && !locked;
endmodule

// File: rtl/i2c_sl_checker.sv
module i2c_sl_checker
    import i2c_sl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_nack,
    input logic              lock_clr,
    input logic              sr_rd,
    input logic              thr_wr,
    input logic              rhr_rd,
    input logic              rx_byte,
    input logic [STAT_W-1:0] status,
    input logic              irq,
    input logic              dma_tx_req
);
    assert_nack_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> (status[B_NACK] && status[B_LOCK]));

    assert_lock_blocks_dma_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_LOCK] |-> !dma_tx_req);

    assert_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_clr && !ev_nack) |=> !status[B_LOCK]);

    assert_write_drops_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !status[B_TXCOMP]);

    assert_read_clears_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rd && !ev_nack) |=> !status[B_NACK]);

    assert_rx_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd && !rx_byte) |=> !status[B_RXRDY]);

    assert_quiet_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
endmodule

bind i2c_status_lock i2c_sl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_nack    (ev_nack),
    .lock_clr   (lock_clr),
    .sr_rd      (sr_rd),
    .thr_wr     (thr_wr),
    .rhr_rd     (rhr_rd),
    .rx_byte    (rx_byte),
    .status     (status),
    .irq        (irq),
    .dma_tx_req (dma_tx_req)
);

// File: tb/sim_i2c_status_lock.sv
module sim_i2c_status_lock;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VALID = 32'h0080_01C7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thr_wr = 0, thr_clr = 0, rhr_rd = 0, rhr_clr = 0, lock_clr = 0;
    logic start_rd = 0, sr_rd = 0, ier_wr = 0, idr_wr = 0;
    logic [31:0] mask_wdata = '0;
    logic tx_load = 0, rx_byte = 0, ev_nack = 0, ev_stop = 0, shifter_idle = 1;
    logic [31:0] status;
    logic irq, dma_tx_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    bit m_thr = 0, m_rx = 0, m_lock = 0, m_end = 1;
    bit m_nack = 0, m_ovr = 0, m_unr = 0;
    logic [31:0] m_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_status_lock u0 (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_clr(thr_clr),
        .rhr_rd(rhr_rd), .rhr_clr(rhr_clr), .lock_clr(lock_clr),
        .start_rd(start_rd), .sr_rd(sr_rd), .ier_wr(ier_wr), .idr_wr(idr_wr),
        .mask_wdata(mask_wdata), .tx_load(tx_load), .rx_byte(rx_byte),
        .ev_nack(ev_nack), .ev_stop(ev_stop), .shifter_idle(shifter_idle),
        .status(status), .irq(irq), .dma_tx_req(dma_tx_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        s[0]  = !m_thr && shifter_idle && m_end;
        s[1]  = m_rx;
        s[2]  = !m_thr;
        s[6]  = m_ovr;
        s[7]  = m_unr;
        s[8]  = m_nack;
        s[23] = m_lock;
        return s;
    endfunction

    task automatic model_update();
        bit ld_ok, unr_e, ovr_e, take;
        logic [31:0] setm, clrm;
        ld_ok = tx_load && !m_lock;
        take  = rhr_rd || rhr_clr;
        unr_e = ld_ok && !m_thr;
        ovr_e = rx_byte && m_rx && !take;
        m_nack = ev_nack || (m_nack && !sr_rd);
        m_ovr  = ovr_e || (m_ovr && !sr_rd);
        m_unr  = unr_e || (m_unr && !sr_rd);
        if (thr_clr) m_thr = 0; else if (thr_wr) m_thr = 1; else if (ld_ok) m_thr = 0;
        if (rx_byte) m_rx = 1; else if (take) m_rx = 0;
        if (ev_nack) m_lock = 1; else if (lock_clr) m_lock = 0;
        if (thr_wr || start_rd) m_end = 0; else if (ev_stop || ev_nack) m_end = 1;
        setm = ier_wr ? (mask_wdata & VALID) : '0;
        clrm = idr_wr ? mask_wdata : '0;
        m_mask = (m_mask | setm) & ~clrm;
    endtask

    task automatic check_all();
        logic [31:0] e;
        e = exp_status();
        chk(status[0] == e[0], "R2 transmission complete", status, e);
        chk(status[1] == e[1], "R6 receive ready", status, e);
        chk(status[2] == e[2], "R12 transmit ready", status, e);
        chk(status[6] == e[6], "R7 overrun", status, e);
        chk(status[7] == e[7], "R8 underrun", status, e);
        chk(status[8] == e[8], "R9 nack sticky", status, e);
        chk(status[23] == e[23], "R3 lock", status, e);
        chk(status == e, "R3 whole status word", status, e);
        chk(irq == (|(e & m_mask)), "R11 irq", {31'b0, irq}, {31'b0, |(e & m_mask)});
        chk(dma_tx_req == (e[2] && !m_lock), "R12 dma request", {31'b0, dma_tx_req}, {31'b0, e[2] && !m_lock});
    endtask

    task automatic clear_pulses();
        thr_wr = 0; thr_clr = 0; rhr_rd = 0; rhr_clr = 0; lock_clr = 0;
        start_rd = 0; sr_rd = 0; ier_wr = 0; idr_wr = 0; mask_wdata = '0;
        tx_load = 0; rx_byte = 0; ev_nack = 0; ev_stop = 0;
    endtask

    // inputs are already set; apply them for one edge, then check
    task automatic run_cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        clear_pulses();
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(status == 32'h5, "R1 reset status", status, 32'h5);
        chk(irq == 1'b0, "R1 reset irq", {31'b0, irq}, 32'h0);
        chk(dma_tx_req == 1'b1, "R1 reset dma request", {31'b0, dma_tx_req}, 32'h1);
        rst_n = 1;
        @(negedge clk);

        // R2: write drops completion, load then STOP restores it
        thr_wr = 1; run_cycle();
        chk(status[0] == 0, "R2 after write", status, 32'h0);
        tx_load = 1; run_cycle();
        ev_stop = 1; run_cycle();
        chk(status[0] == 1, "R2 after stop", status, 32'h1);
        start_rd = 1; run_cycle();
        chk(status[0] == 0, "R2 after read start", status, 32'h0);

        // R3: NACK with empty register
        ev_nack = 1; run_cycle();
        chk(status == 32'h0080_0105, "R3 nack lock done together", status, 32'h0080_0105);
        // R4: data written while locked stays
        thr_wr = 1; run_cycle();
        tx_load = 1; run_cycle();
        chk(status[2:0] == 3'b000, "R4 frozen holding register", status, 32'h0);
        chk(status[7] == 0, "R4 no underrun while locked", status, 32'h0);
        chk(status[8] == 1, "R4 nack kept", status, 32'h100);
        chk(dma_tx_req == 0, "R4 dma held", {31'b0, dma_tx_req}, 32'h0);
        // R5: lock clear beside NACK keeps lock
        lock_clr = 1; ev_nack = 1; run_cycle();
        chk(status[23] == 1, "R5 nack beats lock clear", status, 32'h0080_0000);
        lock_clr = 1; run_cycle();
        chk(status[23] == 0, "R5 lock cleared", status, 32'h0);
        thr_clr = 1; thr_wr = 1; run_cycle();
        chk(status[2] == 1, "R5 flush beats write", status, 32'h4);

        // R9: read beside NACK keeps flag, read alone clears
        sr_rd = 1; ev_nack = 1; run_cycle();
        chk(status[8] == 1, "R9 nack survives read", status, 32'h100);
        sr_rd = 1; lock_clr = 1; run_cycle();
        chk(status[8] == 0, "R9 nack cleared", status, 32'h0);

        // R8: underrun
        tx_load = 1; run_cycle();
        chk(status[7] == 1, "R8 underrun set", status, 32'h80);

        // R6/R7: receive path
        rx_byte = 1; run_cycle();
        chk(status[1] == 1, "R6 rx ready", status, 32'h2);
        rx_byte = 1; rhr_rd = 1; run_cycle();
        chk(status[1] == 1 && status[6] == 0, "R6 byte beats read, no overrun", status, 32'h2);
        rx_byte = 1; run_cycle();
        chk(status[6] == 1, "R7 overrun set", status, 32'h40);
        rhr_clr = 1; run_cycle();
        chk(status[1] == 0, "R5 receive flush", status, 32'h0);
        sr_rd = 1; run_cycle();

        // R10: mask set, clear, and collision
        ev_stop = 1; run_cycle();
        ier_wr = 1; mask_wdata = 32'h1; run_cycle();
        chk(irq == 1, "R10 enable raises irq", {31'b0, irq}, 32'h1);
        idr_wr = 1; mask_wdata = 32'h1; run_cycle();
        chk(irq == 0, "R10 disable drops irq", {31'b0, irq}, 32'h0);
        ier_wr = 1; idr_wr = 1; mask_wdata = 32'h1; run_cycle();
        chk(irq == 0, "R10 disable wins", {31'b0, irq}, 32'h0);
        ier_wr = 1; mask_wdata = 32'h0000_0010; run_cycle();
        chk(irq == 0, "R10 unused bit ignored", {31'b0, irq}, 32'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            thr_wr   = ($urandom % 6) == 0;
            thr_clr  = ($urandom % 20) == 0;
            rhr_rd   = ($urandom % 5) == 0;
            rhr_clr  = ($urandom % 25) == 0;
            lock_clr = ($urandom % 10) == 0;
            start_rd = ($urandom % 15) == 0;
            sr_rd    = ($urandom % 6) == 0;
            ier_wr   = ($urandom % 12) == 0;
            idr_wr   = ($urandom % 12) == 0;
            mask_wdata = $urandom;
            tx_load  = ($urandom % 5) == 0;
            rx_byte  = ($urandom % 5) == 0;
            ev_nack  = ($urandom % 25) == 0;
            ev_stop  = ($urandom % 8) == 0;
            shifter_idle = ($urandom % 4) != 0;
            run_cycle();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule